// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test access port of a small controller-style chip. A board tester drives four serial pins (test clock, mode select, data in, data out). A sixteen-state controller, stepped by the mode-select line, sequences instruction and data scans. A four-bit instruction register chooses one of four data registers placed between data-in and data-out. These are a one-bit bypass stage, a 32-bit identification register, a boundary register that wraps every digital pad, and a one-bit device-reset register.

Each pad has an output value, an output enable and an input. Each pad's boundary cell has a shift stage and a separate update latch, so a scan can observe the pads or preload drive values without disturbing the chip. When the external-test instruction is loaded, the latches take over the pads. The device-reset instruction lets the tester hold the core in reset from the scan chain. While the core is in reset by either route, pad drivers are released unless external test owns them.

The port works only when a fuse input is set and a software disable input is clear. Otherwise it is held in its reset state with data-out disabled. All state is clocked by the test clock alone, so the system clock may be slow or stopped.

Top module: `bscan_tap`

## Requirements
- R1: Whenever the controller passes through Test-Logic-Reset, the identification instruction (code 0x1) becomes current. The next data scan then shifts out the 32-bit identification value, least significant bit first, and that bit is always 1.
- R2: The controller follows the standard sixteen-state graph on rising test-clock edges under mode select. Five clocks with mode select high reach Test-Logic-Reset from any state. Data-out changes on falling edges, and its enable is high only during Shift-IR and Shift-DR.
- R3: The instruction register is 4 bits wide and shifts least significant bit first. Capture-IR loads 0b0001. A new instruction takes effect on the rising edge that leaves Update-IR. The codes are external test 0x0, identification 0x1, sample/preload 0x2, device reset 0xC and bypass 0xF.
- R4: Under bypass, and under every code not listed in R3, a single stage that captures 0 sits between data-in and data-out, so data emerges one shift later.
- R5: The boundary register holds 3 bits per pad. Counting from the data-in end, it holds pad 0's input, then its output enable, then its output value, then the same three for pad 1, and so on. The output value of the last pad sits next to data-out. Under sample/preload or external test, Capture-DR loads the present pad input, output value and output enable.
- R6: Under sample/preload the pads follow the core's output value and enable. Update-DR copies the boundary shift stage into the update latches. The latches change at no other time while the port is enabled.
- R7: From the Update-IR edge that makes external test current, each pad's output value and enable come from its update latch, regardless of any reset.
- R8: Under the device-reset instruction, a one-bit register is shifted by data scans, and the reset request output is high while this instruction is current and the register holds 1. The register keeps its value across instruction changes and is cleared only by shifting in 0 or by Test-Logic-Reset.
- R9: While the external active-low reset input is low or the reset request is high, and external test is not current, every pad output enable is 0. The pad output values still follow the core.
- R10: When the fuse input is 0 or the software disable input is 1, the controller is held in Test-Logic-Reset, mode select is ignored, and data-out is disabled. In this condition the instruction returns to identification, the reset register clears and the update latches clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; the only clock of the block |
| tms | input | 1 | Mode select, sampled on rising test-clock edges |
| tdi | input | 1 | Serial scan data in |
| tdo | output | 1 | Serial scan data out, changes on falling edges |
| tdoEn | output | 1 | Drive enable for the data-out pad |
| fuseEn | input | 1 | Fuse-controlled enable of the port |
| swDisable | input | 1 | Software disable of the port, active high |
| extResetN | input | 1 | State of the external reset pin, active low |
| devResetReq | output | 1 | Core reset request from the reset register |
| coreOut | input | N_PINS | Functional output value per pad |
| coreOe | input | N_PINS | Functional output enable per pad |
| padIn | input | N_PINS | Value received at each pad |
| padOut | output | N_PINS | Output value sent to each pad driver |
| padOe | output | N_PINS | Output enable sent to each pad driver |

## Verification
The clocked properties assume that mode select, data-in, the reset pin and the core signals change only away from the rising test-clock edge, and that the two enable inputs act asynchronously. The history-based checks also assume at least one full clock has passed since the port was last enabled. The stimulus drives every input one time unit after a falling edge. It toggles the enables only at those points, and it compares data-out and the pad outputs just after falling edges, once both edge types have settled.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [3:0] {
    TLR    = 4'h0, RTI    = 4'h1,
    SEL_DR = 4'h2, CAP_DR = 4'h3, SH_DR  = 4'h4, EX1_DR = 4'h5,
    PAU_DR = 4'h6, EX2_DR = 4'h7, UPD_DR = 4'h8,
    SEL_IR = 4'h9, CAP_IR = 4'hA, SH_IR  = 4'hB, EX1_IR = 4'hC,
    PAU_IR = 4'hD, EX2_IR = 4'hE, UPD_IR = 4'hF
  } tapState_t;

  localparam int IR_W = 4;

  // Instruction codes; unlisted codes decode as bypass.
  localparam logic [IR_W-1:0] OP_EXTEST = 4'h0;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'h1;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'h2;
  localparam logic [IR_W-1:0] OP_DEVRST = 4'hC;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [1:0] {
    DR_BYPASS, DR_IDCODE, DR_BOUNDARY, DR_DEVRST
  } drSel_t;

  // Strobes from sequencing logic to the register datapath.
  typedef struct packed {
    logic   captureDr;
    logic   shiftDr;
    logic   updateDr;
    logic   shiftIr;
    logic   tapReset;
    logic   irLsb;
    logic   extestOn;
    drSel_t drSel;
  } tapStrobe_t;

endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       tapOff,
  input  logic       tms,
  input  logic       tdi,
  output logic       tdoEn,
  output tapStrobe_t strb
);

  tapState_t       state, nextState;
  logic [IR_W-1:0] irShift, irLatch;
  drSel_t          drSel;
  logic            pastValid;

  always_comb begin
    nextState = state;
    unique case (state)
      TLR:    nextState = tms ? TLR    : RTI;
      RTI:    nextState = tms ? SEL_DR : RTI;
      SEL_DR: nextState = tms ? SEL_IR : CAP_DR;
      CAP_DR: nextState = tms ? EX1_DR : SH_DR;
      SH_DR:  nextState = tms ? EX1_DR : SH_DR;
      EX1_DR: nextState = tms ? UPD_DR : PAU_DR;
      PAU_DR: nextState = tms ? EX2_DR : PAU_DR;
      EX2_DR: nextState = tms ? UPD_DR : SH_DR;
      UPD_DR: nextState = tms ? SEL_DR : RTI;
      SEL_IR: nextState = tms ? TLR    : CAP_IR;
      CAP_IR: nextState = tms ? EX1_IR : SH_IR;
      SH_IR:  nextState = tms ? EX1_IR : SH_IR;
      EX1_IR: nextState = tms ? UPD_IR : PAU_IR;
      PAU_IR: nextState = tms ? EX2_IR : PAU_IR;
      EX2_IR: nextState = tms ? UPD_IR : SH_IR;
      UPD_IR: nextState = tms ? SEL_DR : RTI;
      default: nextState = TLR;
    endcase
  end

  always_ff @(posedge tck or posedge tapOff) begin
    if (tapOff) begin
      state     <= TLR;
      irShift   <= IR_CAPTURE;
      irLatch   <= OP_IDCODE;
      pastValid <= 1'b0;
    end else begin
      state     <= nextState;
      pastValid <= 1'b1;
      if (state == CAP_IR)     irShift <= IR_CAPTURE;
      else if (state == SH_IR) irShift <= {tdi, irShift[IR_W-1:1]};
      if (state == TLR)         irLatch <= OP_IDCODE;
      else if (state == UPD_IR) irLatch <= irShift;
    end
  end

  // Output enable for data-out moves on the falling edge, like the data.
  always_ff @(negedge tck or posedge tapOff) begin
    if (tapOff) tdoEn <= 1'b0;
    else        tdoEn <= (state == SH_IR) || (state == SH_DR);
  end

  always_comb begin
    unique case (irLatch)
      OP_EXTEST, OP_SAMPLE: drSel = DR_BOUNDARY;
      OP_IDCODE:            drSel = DR_IDCODE;
      OP_DEVRST:            drSel = DR_DEVRST;
      default:              drSel = DR_BYPASS;
    endcase
  end

  assign strb.captureDr = (state == CAP_DR);
  assign strb.shiftDr   = (state == SH_DR);
  assign strb.updateDr  = (state == UPD_DR);
  assign strb.shiftIr   = (state == SH_IR);
  assign strb.tapReset  = (state == TLR);
  assign strb.irLsb     = irShift[0];
  assign strb.extestOn  = (irLatch == OP_EXTEST);
  assign strb.drSel     = drSel;

  assert_ir_default_R1: assert property (@(posedge tck) disable iff (tapOff)
    (state == TLR) |=> (irLatch == OP_IDCODE));

  assert_ir_update_only_R3: assert property (@(posedge tck) disable iff (tapOff || !pastValid)
    (irLatch != $past(irLatch)) |-> ($past(state) == UPD_IR || $past(state) == TLR));

  assert_tdo_window_R2: assert property (@(posedge tck) disable iff (tapOff)
    tdoEn |-> (state == SH_IR || state == SH_DR));

endmodule

// File: rtl/bscan_dpath.sv
module bscan_dpath
  import bscan_pkg::*;
#(
  parameter int          N_PINS  = 4,
  parameter logic [31:0] ID_CODE = 32'h2B7A_C03F
) (
  input  logic              tck,
  input  logic              tapOff,
  input  logic              tdi,
  input  tapStrobe_t        strb,
  input  logic              extResetN,
  input  logic [N_PINS-1:0] coreOut,
  input  logic [N_PINS-1:0] coreOe,
  input  logic [N_PINS-1:0] padIn,
  output logic [N_PINS-1:0] padOut,
  output logic [N_PINS-1:0] padOe,
  output logic              devResetReq,
  output logic              tdo
);

  localparam int ID_W  = 32;
  localparam int BSR_W = 3 * N_PINS;

  logic             bypassReg, rstReg, pastValid;
  logic [ID_W-1:0]  idShift;
  logic [BSR_W-1:0] bsrShift, capVec;
  logic [N_PINS-1:0] latDat, latOe, updDat, updOe;
  logic             drOut, devInReset;

  // Cell of pad p: output value at base, enable at base+1, input at base+2.
  for (genvar p = 0; p < N_PINS; p++) begin : g_cell
    localparam int BASE = 3 * (N_PINS - 1 - p);
    assign capVec[BASE +: 3] = {padIn[p], padOe[p], padOut[p]};
    assign updDat[p] = bsrShift[BASE];
    assign updOe[p]  = bsrShift[BASE + 1];
  end

  always_ff @(posedge tck or posedge tapOff) begin
    if (tapOff) begin
      bypassReg <= 1'b0;
      rstReg    <= 1'b0;
      idShift   <= '0;
      bsrShift  <= '0;
      latDat    <= '0;
      latOe     <= '0;
      pastValid <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      if (strb.tapReset) rstReg <= 1'b0;
      if (strb.captureDr) begin
        unique case (strb.drSel)
          DR_BYPASS:   bypassReg <= 1'b0;
          DR_IDCODE:   idShift   <= {ID_CODE[ID_W-1:1], 1'b1};
          DR_BOUNDARY: bsrShift  <= capVec;
          default:     ;
        endcase
      end
      if (strb.shiftDr) begin
        unique case (strb.drSel)
          DR_BYPASS:   bypassReg <= tdi;
          DR_IDCODE:   idShift   <= {tdi, idShift[ID_W-1:1]};
          DR_BOUNDARY: bsrShift  <= {tdi, bsrShift[BSR_W-1:1]};
          default:     rstReg    <= tdi;
        endcase
      end
      if (strb.updateDr && strb.drSel == DR_BOUNDARY) begin
        latDat <= updDat;
        latOe  <= updOe;
      end
    end
  end

  always_comb begin
    unique case (strb.drSel)
      DR_BYPASS:   drOut = bypassReg;
      DR_IDCODE:   drOut = idShift[0];
      DR_BOUNDARY: drOut = bsrShift[0];
      default:     drOut = rstReg;
    endcase
  end

  always_ff @(negedge tck or posedge tapOff) begin
    if (tapOff) tdo <= 1'b0;
    else        tdo <= strb.shiftIr ? strb.irLsb : drOut;
  end

  assign devResetReq = (strb.drSel == DR_DEVRST) && rstReg;
  assign devInReset  = !extResetN || devResetReq;
  assign padOut      = strb.extestOn ? latDat : coreOut;
  assign padOe       = strb.extestOn ? latOe : (devInReset ? '0 : coreOe);

  assert_latch_hold_R6: assert property (@(posedge tck) disable iff (tapOff || !pastValid)
    ((latDat != $past(latDat)) || (latOe != $past(latOe)))
      |-> $past(strb.updateDr && (strb.drSel == DR_BOUNDARY)));

  assert_req_source_R8: assert property (@(posedge tck) disable iff (tapOff || !pastValid)
    $rose(devResetReq) |-> ($past(strb.shiftDr && (strb.drSel == DR_DEVRST))
                            || ($past(strb.drSel) != DR_DEVRST)));

  assert_reset_hiz_R9: assert property (@(posedge tck) disable iff (tapOff)
    (!strb.extestOn && (!extResetN || devResetReq)) |-> ($countones(padOe) == 0));

endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
  import bscan_pkg::*;
#(
  parameter int          N_PINS  = 4,
  parameter logic [31:0] ID_CODE = 32'h2B7A_C03F
) (
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdoEn,
  input  logic              fuseEn,
  input  logic              swDisable,
  input  logic              extResetN,
  output logic              devResetReq,
  input  logic [N_PINS-1:0] coreOut,
  input  logic [N_PINS-1:0] coreOe,
  input  logic [N_PINS-1:0] padIn,
  output logic [N_PINS-1:0] padOut,
  output logic [N_PINS-1:0] padOe
);

  logic       tapOff;
  tapStrobe_t strb;

  assign tapOff = !fuseEn || swDisable;

  bscan_ctrl ctrl_i (
    .tck   (tck),
    .tapOff(tapOff),
    .tms   (tms),
    .tdi   (tdi),
    .tdoEn (tdoEn),
    .strb  (strb)
  );

  bscan_dpath #(.N_PINS(N_PINS), .ID_CODE(ID_CODE)) dpath_i (
    .tck        (tck),
    .tapOff     (tapOff),
    .tdi        (tdi),
    .strb       (strb),
    .extResetN  (extResetN),
    .coreOut    (coreOut),
    .coreOe     (coreOe),
    .padIn      (padIn),
    .padOut     (padOut),
    .padOe      (padOe),
    .devResetReq(devResetReq),
    .tdo        (tdo)
  );

endmodule

// File: tb/bscan_tap_tb_top.sv
module bscan_tap_tb_top;

  localparam int TCK_PERIOD = 10;
  localparam int NP = 4;
  localparam logic [31:0] IDV = 32'h2B7A_C03F;

  localparam int ST_TLR = 0, ST_RTI = 1, ST_SELDR = 2, ST_CAPDR = 3, ST_SHDR = 4,
                 ST_EX1DR = 5, ST_PAUDR = 6, ST_EX2DR = 7, ST_UPDDR = 8,
                 ST_SELIR = 9, ST_CAPIR = 10, ST_SHIR = 11, ST_EX1IR = 12,
                 ST_PAUIR = 13, ST_EX2IR = 14, ST_UPDIR = 15;

  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic fuseEn = 1'b1, swDisable = 1'b0, extResetN = 1'b1;
  logic [NP-1:0] coreOut = '0, coreOe = '0, padIn = '0;
  logic tdo, tdoEn, devResetReq;
  logic [NP-1:0] padOut, padOe;

  int checks = 0, fails = 0;

  // Reference model state
  int      mSt = ST_TLR;
  bit [3:0] mIr = 4'h1;
  bit      mIrq[$];
  bit      mDrq[$];
  bit      mRst = 1'b0;
  bit [NP-1:0] mLatD = '0, mLatO = '0;

  always #(TCK_PERIOD/2) tck = ~tck;

  bscan_tap #(.N_PINS(NP), .ID_CODE(IDV)) dut_i (
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .fuseEn(fuseEn), .swDisable(swDisable), .extResetN(extResetN),
    .devResetReq(devResetReq), .coreOut(coreOut), .coreOe(coreOe),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nxt(input int s, input bit m);
    case (s)
      ST_TLR:   return m ? ST_TLR   : ST_RTI;
      ST_RTI:   return m ? ST_SELDR : ST_RTI;
      ST_SELDR: return m ? ST_SELIR : ST_CAPDR;
      ST_CAPDR, ST_SHDR: return m ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: return m ? ST_UPDDR : ST_PAUDR;
      ST_PAUDR: return m ? ST_EX2DR : ST_PAUDR;
      ST_EX2DR: return m ? ST_UPDDR : ST_SHDR;
      ST_SELIR: return m ? ST_TLR   : ST_CAPIR;
      ST_CAPIR, ST_SHIR: return m ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: return m ? ST_UPDIR : ST_PAUIR;
      ST_PAUIR: return m ? ST_EX2IR : ST_PAUIR;
      ST_EX2IR: return m ? ST_UPDIR : ST_SHIR;
      default:  return m ? ST_SELDR : ST_RTI;   // both update states
    endcase
  endfunction

  // Boundary vector per R5: pad p's value at 3*(NP-1-p), enable +1, input +2.
  function automatic logic [63:0] buildVec(input logic [NP-1:0] d, input logic [NP-1:0] o, input logic [NP-1:0] i);
    logic [63:0] v = '0;
    for (int p = 0; p < NP; p++) begin
      v[3*(NP-1-p)]     = d[p];
      v[3*(NP-1-p) + 1] = o[p];
      v[3*(NP-1-p) + 2] = i[p];
    end
    return v;
  endfunction

  function automatic bit isBoundary(input bit [3:0] op);
    return (op == 4'h0) || (op == 4'h2);
  endfunction

  task automatic modelPins(output bit [NP-1:0] eo, output bit [NP-1:0] eoe, output bit er);
    bit ext = (mIr == 4'h0);
    er  = (mIr == 4'hC) && mRst;
    eo  = ext ? mLatD : coreOut;
    eoe = ext ? mLatO : ((!extResetN || er) ? '0 : coreOe);
  endtask

  task automatic modelOff();
    mSt = ST_TLR; mIr = 4'h1; mRst = 1'b0; mLatD = '0; mLatO = '0;
    mIrq = '{1'b1, 1'b0, 1'b0, 1'b0};
  endtask

  task automatic modelEdge(input bit m, input bit d);
    bit [NP-1:0] eo, eoe; bit er;
    logic [63:0] v;
    int ns = nxt(mSt, m);
    modelPins(eo, eoe, er);
    case (mSt)
      ST_TLR:   begin mIr = 4'h1; mRst = 1'b0; end
      ST_CAPIR: mIrq = '{1'b1, 1'b0, 1'b0, 1'b0};
      ST_SHIR:  begin void'(mIrq.pop_front()); mIrq.push_back(d); end
      ST_UPDIR: mIr = {mIrq[3], mIrq[2], mIrq[1], mIrq[0]};
      ST_CAPDR: begin
        mDrq = {};
        if (isBoundary(mIr)) begin
          v = buildVec(eo, eoe, padIn);
          for (int b = 0; b < 3*NP; b++) mDrq.push_back(v[b]);
        end else if (mIr == 4'h1) begin
          for (int b = 0; b < 32; b++) mDrq.push_back(IDV[b] | (b == 0));
        end else if (mIr == 4'hC) mDrq.push_back(mRst);
        else mDrq.push_back(1'b0);
      end
      ST_SHDR: begin
        void'(mDrq.pop_front()); mDrq.push_back(d);
        if (mIr == 4'hC) mRst = d;
      end
      ST_UPDDR: if (isBoundary(mIr))
        for (int p = 0; p < NP; p++) begin
          mLatD[p] = mDrq[3*(NP-1-p)];
          mLatO[p] = mDrq[3*(NP-1-p) + 1];
        end
      default: ;
    endcase
    mSt = ns;
  endtask

  task automatic compare();
    bit [NP-1:0] eo, eoe; bit er;
    bit expEn = (fuseEn && !swDisable) && (mSt == ST_SHIR || mSt == ST_SHDR);
    modelPins(eo, eoe, er);
    chk(tdoEn === expEn, "R2 data-out enable", tdoEn, expEn);
    if (expEn) begin
      bit et = (mSt == ST_SHIR) ? mIrq[0] : mDrq[0];
      chk(tdo === et, "R2 data-out bit", tdo, et);
    end
    chk(padOut === eo, "R7 pad value", padOut, eo);
    chk(padOe === eoe, "R9 pad enable", padOe, eoe);
    chk(devResetReq === er, "R8 reset request", devResetReq, er);
  endtask

  task automatic tick(input bit m, input bit d);
    tms = m; tdi = d;
    @(posedge tck); #1;
    if (fuseEn && !swDisable) modelEdge(m, d); else modelOff();
    @(negedge tck); #1;
    compare();
  endtask

  task automatic irScan(input logic [3:0] op, output logic [3:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      cap[i] = tdo;
      tick(i == 3, op[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic drScan(input int n, input logic [63:0] din, input int pauseAt, output logic [63:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick((i == n-1) || (i == pauseAt-1), din[i]);
      if (i == pauseAt-1) begin tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0); end
    end
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #(TCK_PERIOD * 50000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [3:0]  ic;
    logic [63:0] dq;
    #1 fuseEn = 1'b0;
    modelOff();
    @(negedge tck); #1;
    // R10: port held off at start
    chk(tdoEn === 1'b0, "R10 off: data-out disabled", tdoEn, 0);
    chk(padOut === coreOut, "R10 off: pads functional", padOut, coreOut);
    tick(0, 0); tick(1, 0);
    fuseEn = 1'b1;
    tick(1, 0); tick(0, 0);

    // R1: first data scan gives the identification value
    drScan(32, 64'h0, -1, dq);
    chk(dq[31:0] === IDV, "R1 identification scan", dq[31:0], IDV);
    chk(dq[0] === 1'b1, "R1 identification lsb", dq[0], 1);

    // R2: same scan split by pause states
    drScan(32, 64'h0, 16, dq);
    chk(dq[31:0] === IDV, "R2 scan through pause", dq[31:0], IDV);

    // R3 and R4: capture pattern, then one-stage bypass
    irScan(4'hF, ic);
    chk(ic === 4'b0001, "R3 capture pattern", ic, 4'b0001);
    drScan(8, 64'hB5, -1, dq);
    chk(dq[7:0] === 8'h6A, "R4 bypass delay", dq[7:0], 8'h6A);
    irScan(4'h7, ic);
    drScan(8, 64'h3C, -1, dq);
    chk(dq[7:0] === 8'h78, "R4 unlisted code as bypass", dq[7:0], 8'h78);

    // R5 and R6: sample and preload
    coreOut = 4'b1010; coreOe = 4'b0110; padIn = 4'b0011;
    irScan(4'h2, ic);
    drScan(3*NP, buildVec(4'b1100, 4'b1111, 4'b0000), -1, dq);
    chk(dq[3*NP-1:0] === buildVec(4'b1010, 4'b0110, 4'b0011), "R5 sample capture", dq, buildVec(4'b1010, 4'b0110, 4'b0011));
    chk(padOut === coreOut && padOe === coreOe, "R6 pads stay functional", {padOut, padOe}, {coreOut, coreOe});

    // R7: external test drives preloaded values, captures pads
    irScan(4'h0, ic);
    chk(padOut === 4'b1100 && padOe === 4'b1111, "R7 preload driven", {padOut, padOe}, 8'hCF);
    padIn = 4'b0101;
    drScan(3*NP, buildVec(4'b0011, 4'b0101, 4'b0000), -1, dq);
    chk(dq[3*NP-1:0] === buildVec(4'b1100, 4'b1111, 4'b0101), "R5 extest capture", dq, buildVec(4'b1100, 4'b1111, 4'b0101));
    chk(padOut === 4'b0011 && padOe === 4'b0101, "R7 update drives pads", {padOut, padOe}, 8'h35);

    // R9: external reset pin
    extResetN = 1'b0;
    tick(0, 0);
    chk(padOe === 4'b0101, "R7 extest overrides reset", padOe, 4'b0101);
    irScan(4'h2, ic);
    chk(padOe === 4'b0000 && padOut === coreOut, "R9 pin reset releases pads", {padOut, padOe}, {coreOut, 4'b0000});
    extResetN = 1'b1;
    tick(0, 0);
    chk(padOe === coreOe, "R9 pads restored", padOe, coreOe);

    // R8: reset instruction
    irScan(4'hC, ic);
    chk(devResetReq === 1'b0, "R8 request idle", devResetReq, 0);
    drScan(1, 64'h1, -1, dq);
    chk(devResetReq === 1'b1, "R8 request set", devResetReq, 1);
    chk(padOe === 4'b0000, "R9 request releases pads", padOe, 0);
    irScan(4'hF, ic);
    chk(devResetReq === 1'b0, "R8 drops on instruction change", devResetReq, 0);
    irScan(4'hC, ic);
    chk(devResetReq === 1'b1, "R8 register retained", devResetReq, 1);
    drScan(1, 64'h0, -1, dq);
    chk(dq[0] === 1'b1 && devResetReq === 1'b0, "R8 cleared by shift", {dq[0], devResetReq}, 2'b10);
    drScan(1, 64'h1, -1, dq);
    for (int k = 0; k < 5; k++) tick(1, 0);
    tick(0, 0);
    chk(devResetReq === 1'b0, "R8 cleared by logic reset", devResetReq, 0);
    drScan(32, 64'h0, -1, dq);
    chk(dq[31:0] === IDV, "R1 identification after logic reset", dq[31:0], IDV);

    // R10: software disable and fuse
    irScan(4'h0, ic);
    swDisable = 1'b1;
    for (int k = 0; k < 6; k++) tick(k[0], 1'b1);
    chk(tdoEn === 1'b0 && padOut === coreOut, "R10 disabled port", {tdoEn, padOut}, {1'b0, coreOut});
    swDisable = 1'b0;
    tick(0, 0);
    irScan(4'h0, ic);
    chk(padOut === 4'b0000 && padOe === 4'b0000, "R10 latches cleared", {padOut, padOe}, 0);
    fuseEn = 1'b0;
    tick(0, 0); tick(1, 0); tick(0, 0);
    fuseEn = 1'b1;
    tick(0, 0);
    drScan(32, 64'h0, -1, dq);
    chk(dq[31:0] === IDV, "R10 fuse off returns to identification", dq[31:0], IDV);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule